// File: doc/BRIEF.md
# Region Coherence Tracking Array

This block stores coarse-grain coherence entries, one for each aligned memory region. A region is a power-of-two group of cache lines. The array is set-associative. A request presents a line address. The block drops the within-region offset bits and splits the rest into a set index (low bits) and a region tag (high bits). A lookup returns one cycle later with a hit flag, the 3-bit region state, the memory controller identifier and the number of lines of that region that the local cache holds. The region state transition logic sits outside this block. It writes new states through the update port. When an update misses, the block allocates a way for the region.

The cache reports every line it fills or drops. The block keeps a saturating per-entry line count from these reports. Inclusion between the cache and this array must hold, so the count steers replacement. A way that is free is chosen first. A way whose count is zero comes next, and it is replaced silently. Only when every way still covers cached lines does the least recently used way become the victim. In that case the block asks the cache to evict the victim region. It keeps serving the victim entry, and it installs the new region only when the cache acknowledges.

Top module: `region_track_array`

## Requirements
- R1: After reset every entry is invalid, every lookup misses and `ev_req` is low.
- R2: A lookup presented in cycle N is answered in cycle N+1 with `rsp_valid` high. A miss answers with hit 0, state 0, count 0 and controller ID 0.
- R3: An update that misses, where a free or zero-count way exists in the set, installs the region at that clock edge. Its count is 0 and it takes the given state and controller ID. No eviction request is raised.
- R4: An update that hits rewrites the state and controller ID and leaves the line count unchanged.
- R5: A line fill notification increments the matching entry's count, saturating at LINES (8 by default). A notification for a region that has no entry changes nothing.
- R6: A line drop notification decrements the matching entry's count, with a floor of 0. A fill and a drop for the same entry in one cycle leave the count unchanged.
- R7: The line address decodes as bits [OFF_W-1:0] = line within region (3 bits by default), the next IDX_W bits = set (6 by default), and the rest = tag. Every line offset of a region reaches the same entry.
- R8: Victim choice prefers an invalid way, then a zero-count way even if it was used most recently. A zero-count victim is dropped without an eviction request.
- R9: If several ways tie on the preference of R8, the way other than the most recently used one is chosen. Lookup hits, update hits and installs make a way most recently used.
- R10: If every way in the set has a nonzero count, `ev_req` rises the cycle after the update. `ev_region` = {victim tag, set} is held stable, and the victim still answers lookups. On the clock edge where `ev_ack` is high, the new region is written with count 0 and `ev_req` falls.
- R11: An update presented while `ev_req` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_line | input | LINE_AW | Line address to look up |
| rsp_valid | output | 1 | Lookup answer valid, one cycle after the request |
| rsp_hit | output | 1 | Region entry present |
| rsp_state | output | 3 | Region state (0 on miss) |
| rsp_count | output | CNT_W | Cached-line count (0 on miss) |
| rsp_mcid | output | MCID_W | Memory controller ID (0 on miss) |
| upd_valid | input | 1 | Write state / allocate request |
| upd_line | input | LINE_AW | Line address of the region to write |
| upd_state | input | 3 | New region state |
| upd_mcid | input | MCID_W | Memory controller ID of the region |
| ln_alloc | input | 1 | Cache filled a line |
| ln_alloc_line | input | LINE_AW | Address of the filled line |
| ln_inval | input | 1 | Cache invalidated or evicted a line |
| ln_inval_line | input | LINE_AW | Address of the dropped line |
| ev_req | output | 1 | Request to purge a victim region; the array is busy |
| ev_region | output | LINE_AW-OFF_W | Region address (tag and set) to purge |
| ev_ack | input | 1 | Cache has removed every line of the victim region |

## Verification
A corrupted line count shows up at the next lookup of that region as a wrong `rsp_count`. It also shows up at the next allocation in that set, because the victim choice and the presence of `ev_req` both change. A wrong recency bit stays hidden until the set is full and all ways tie. It then appears one cycle after the update as the wrong region being purged, visible on `ev_region` or in which region misses afterwards. A stuck eviction state shows at once: `ev_req` stays high and later updates are lost.

// File: rtl/rta_pkg.sv
package rta_pkg;

  localparam int STATE_W = 3;

  typedef enum logic {EV_IDLE = 1'b0, EV_WAIT = 1'b1} ev_fsm_e;

  // saturating line-count arithmetic
  function automatic int cnt_up(input int c, input int lim);
    return (c >= lim) ? lim : c + 1;
  endfunction

  function automatic int cnt_dn(input int c);
    return (c <= 0) ? 0 : c - 1;
  endfunction

endpackage

// File: rtl/rta_way_match.sv
module rta_way_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 15,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]       valid_row,
  input  logic [WAYS*TAG_W-1:0] tag_row,
  input  logic [TAG_W-1:0]      tag,
  output logic                  hit,
  output logic [WAY_W-1:0]      way
);
  logic [WAYS-1:0] eq;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign eq[g] = valid_row[g] && (tag_row[g*TAG_W +: TAG_W] == tag);
  end

  always_comb begin
    hit = 1'b0;
    way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (eq[w]) begin
        hit = 1'b1;
        way = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/rta_victim_sel.sv
module rta_victim_sel #(
  parameter int WAYS  = 2,
  parameter int CNT_W = 4,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]       valid_row,
  input  logic [WAYS*CNT_W-1:0] cnt_row,
  input  logic [WAY_W-1:0]      mru,
  output logic [WAY_W-1:0]      way,
  output logic                  need_purge
);
  logic [WAYS-1:0] zero;

  for (genvar g = 0; g < WAYS; g++) begin : g_zero
    assign zero[g] = (cnt_row[g*CNT_W +: CNT_W] == '0);
  end

  always_comb begin
    logic found;
    found = 1'b0;
    way   = mru;
    for (int w = 0; w < WAYS; w++)
      if (!found && !valid_row[w]) begin way = WAY_W'(w); found = 1'b1; end
    for (int w = 0; w < WAYS; w++)
      if (!found && zero[w] && (WAY_W'(w) != mru)) begin way = WAY_W'(w); found = 1'b1; end
    for (int w = 0; w < WAYS; w++)
      if (!found && zero[w]) begin way = WAY_W'(w); found = 1'b1; end
    for (int w = 0; w < WAYS; w++)
      if (!found && (WAY_W'(w) != mru)) begin way = WAY_W'(w); found = 1'b1; end
    need_purge = valid_row[way] && !zero[way];
  end
endmodule

// File: rtl/region_track_array.sv
module region_track_array #(
  parameter int LINE_AW = 24,
  parameter int SETS    = 64,
  parameter int WAYS    = 2,
  parameter int LINES   = 8,
  parameter int MCID_W  = 6,
  localparam int OFF_W  = $clog2(LINES),
  localparam int IDX_W  = $clog2(SETS),
  localparam int TAG_W  = LINE_AW - OFF_W - IDX_W,
  localparam int CNT_W  = $clog2(LINES + 1),
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int REG_AW = LINE_AW - OFF_W,
  localparam int ST_W   = rta_pkg::STATE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  input  logic [LINE_AW-1:0] lk_line,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [ST_W-1:0]    rsp_state,
  output logic [CNT_W-1:0]   rsp_count,
  output logic [MCID_W-1:0]  rsp_mcid,
  input  logic               upd_valid,
  input  logic [LINE_AW-1:0] upd_line,
  input  logic [ST_W-1:0]    upd_state,
  input  logic [MCID_W-1:0]  upd_mcid,
  input  logic               ln_alloc,
  input  logic [LINE_AW-1:0] ln_alloc_line,
  input  logic               ln_inval,
  input  logic [LINE_AW-1:0] ln_inval_line,
  output logic               ev_req,
  output logic [REG_AW-1:0]  ev_region,
  input  logic               ev_ack
);
  import rta_pkg::*;

  function automatic logic [IDX_W-1:0] set_of(input logic [LINE_AW-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [LINE_AW-1:0] a);
    return a[LINE_AW-1 -: TAG_W];
  endfunction

  // entry storage
  logic              v_q   [SETS][WAYS];
  logic [TAG_W-1:0]  tag_q [SETS][WAYS];
  logic [ST_W-1:0]   st_q  [SETS][WAYS];
  logic [CNT_W-1:0]  cnt_q [SETS][WAYS];
  logic [MCID_W-1:0] mc_q  [SETS][WAYS];
  logic [WAY_W-1:0]  mru_q [SETS];

  // eviction state
  ev_fsm_e           ev_st_q;
  logic [IDX_W-1:0]  pend_set_q;
  logic [WAY_W-1:0]  pend_way_q;
  logic [TAG_W-1:0]  pend_tag_q;
  logic [ST_W-1:0]   pend_st_q;
  logic [MCID_W-1:0] pend_mc_q;
  logic [REG_AW-1:0] ev_region_q;

  // response registers
  logic              rsp_valid_q, rsp_hit_q;
  logic [ST_W-1:0]   rsp_state_q;
  logic [CNT_W-1:0]  rsp_count_q;
  logic [MCID_W-1:0] rsp_mcid_q;

  // address decode per port
  logic [IDX_W-1:0] lk_set, up_set, al_set, iv_set;
  logic [TAG_W-1:0] lk_tag, up_tag, al_tag, iv_tag;

  assign lk_set = set_of(lk_line);       assign lk_tag = tag_of(lk_line);
  assign up_set = set_of(upd_line);      assign up_tag = tag_of(upd_line);
  assign al_set = set_of(ln_alloc_line); assign al_tag = tag_of(ln_alloc_line);
  assign iv_set = set_of(ln_inval_line); assign iv_tag = tag_of(ln_inval_line);

  // row flattening for the match and victim units
  logic [WAYS-1:0]       lk_vrow, up_vrow, al_vrow, iv_vrow;
  logic [WAYS*TAG_W-1:0] lk_trow, up_trow, al_trow, iv_trow;
  logic [WAYS*CNT_W-1:0] up_crow;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      lk_vrow[w] = v_q[lk_set][w];  lk_trow[w*TAG_W +: TAG_W] = tag_q[lk_set][w];
      up_vrow[w] = v_q[up_set][w];  up_trow[w*TAG_W +: TAG_W] = tag_q[up_set][w];
      al_vrow[w] = v_q[al_set][w];  al_trow[w*TAG_W +: TAG_W] = tag_q[al_set][w];
      iv_vrow[w] = v_q[iv_set][w];  iv_trow[w*TAG_W +: TAG_W] = tag_q[iv_set][w];
      up_crow[w*CNT_W +: CNT_W] = cnt_q[up_set][w];
    end
  end

  logic             lk_hit, up_hit, al_hit, iv_hit;
  logic [WAY_W-1:0] lk_way, up_way, al_way, iv_way;

  rta_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_m_lk
    (.valid_row(lk_vrow), .tag_row(lk_trow), .tag(lk_tag), .hit(lk_hit), .way(lk_way));
  rta_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_m_up
    (.valid_row(up_vrow), .tag_row(up_trow), .tag(up_tag), .hit(up_hit), .way(up_way));
  rta_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_m_al
    (.valid_row(al_vrow), .tag_row(al_trow), .tag(al_tag), .hit(al_hit), .way(al_way));
  rta_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_m_iv
    (.valid_row(iv_vrow), .tag_row(iv_trow), .tag(iv_tag), .hit(iv_hit), .way(iv_way));

  logic [WAY_W-1:0] vic_way;
  logic             vic_purge;

  rta_victim_sel #(.WAYS(WAYS), .CNT_W(CNT_W)) u_vic (
    .valid_row(up_vrow), .cnt_row(up_crow), .mru(mru_q[up_set]),
    .way(vic_way), .need_purge(vic_purge)
  );

  // named internal events
  logic up_fire, upd_hit_fire, alloc_now, evict_start, install_fire;
  logic cnt_inc, cnt_dec, same_entry;
  logic [IDX_W-1:0]  inst_set;
  logic [WAY_W-1:0]  inst_way;
  logic [TAG_W-1:0]  inst_tag;
  logic [ST_W-1:0]   inst_st;
  logic [MCID_W-1:0] inst_mc;

  assign up_fire      = upd_valid && (ev_st_q == EV_IDLE);
  assign upd_hit_fire = up_fire && up_hit;
  assign alloc_now    = up_fire && !up_hit && !vic_purge;
  assign evict_start  = up_fire && !up_hit && vic_purge;
  assign install_fire = alloc_now || ((ev_st_q == EV_WAIT) && ev_ack);

  assign cnt_inc    = ln_alloc && al_hit;
  assign cnt_dec    = ln_inval && iv_hit;
  assign same_entry = cnt_inc && cnt_dec && (al_set == iv_set) && (al_way == iv_way);

  assign inst_set = alloc_now ? up_set    : pend_set_q;
  assign inst_way = alloc_now ? vic_way   : pend_way_q;
  assign inst_tag = alloc_now ? up_tag    : pend_tag_q;
  assign inst_st  = alloc_now ? upd_state : pend_st_q;
  assign inst_mc  = alloc_now ? upd_mcid  : pend_mc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        mru_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          v_q[s][w]   <= 1'b0;
          cnt_q[s][w] <= '0;
        end
      end
      ev_st_q     <= EV_IDLE;
      pend_set_q  <= '0;
      pend_way_q  <= '0;
      pend_tag_q  <= '0;
      pend_st_q   <= '0;
      pend_mc_q   <= '0;
      ev_region_q <= '0;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_state_q <= '0;
      rsp_count_q <= '0;
      rsp_mcid_q  <= '0;
    end else begin
      // lookup answer reflects the table before this edge's writes
      rsp_valid_q <= lk_valid;
      rsp_hit_q   <= lk_valid && lk_hit;
      rsp_state_q <= (lk_valid && lk_hit) ? st_q[lk_set][lk_way]  : '0;
      rsp_count_q <= (lk_valid && lk_hit) ? cnt_q[lk_set][lk_way] : '0;
      rsp_mcid_q  <= (lk_valid && lk_hit) ? mc_q[lk_set][lk_way]  : '0;
      if (lk_valid && lk_hit) mru_q[lk_set] <= lk_way;

      if (cnt_inc && !same_entry)
        cnt_q[al_set][al_way] <= CNT_W'(cnt_up(int'(cnt_q[al_set][al_way]), LINES));
      if (cnt_dec && !same_entry)
        cnt_q[iv_set][iv_way] <= CNT_W'(cnt_dn(int'(cnt_q[iv_set][iv_way])));

      if (upd_hit_fire) begin
        st_q[up_set][up_way] <= upd_state;
        mc_q[up_set][up_way] <= upd_mcid;
        mru_q[up_set]        <= up_way;
      end

      if (evict_start) begin
        ev_st_q     <= EV_WAIT;
        pend_set_q  <= up_set;
        pend_way_q  <= vic_way;
        pend_tag_q  <= up_tag;
        pend_st_q   <= upd_state;
        pend_mc_q   <= upd_mcid;
        ev_region_q <= {tag_q[up_set][vic_way], up_set};
      end else if ((ev_st_q == EV_WAIT) && ev_ack) begin
        ev_st_q <= EV_IDLE;
      end

      if (install_fire) begin
        v_q[inst_set][inst_way]   <= 1'b1;
        tag_q[inst_set][inst_way] <= inst_tag;
        st_q[inst_set][inst_way]  <= inst_st;
        mc_q[inst_set][inst_way]  <= inst_mc;
        cnt_q[inst_set][inst_way] <= '0;
        mru_q[inst_set]           <= inst_way;
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_state = rsp_state_q;
  assign rsp_count = rsp_count_q;
  assign rsp_mcid  = rsp_mcid_q;
  assign ev_req    = (ev_st_q == EV_WAIT);
  assign ev_region = ev_region_q;
endmodule

// File: rtl/rta_checker.sv
module rta_checker #(
  parameter int LINES  = 8,
  parameter int CNT_W  = 4,
  parameter int REG_AW = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [2:0]        rsp_state,
  input logic [CNT_W-1:0]  rsp_count,
  input logic              ev_req,
  input logic              ev_ack,
  input logic [REG_AW-1:0] ev_region,
  input logic              install_fire,
  input logic              evict_start
);
  // R2: a miss carries no state or count
  a_r2_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_state == '0 && rsp_count == '0));

  // R5: the reported count never exceeds the lines of a region
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (int'(rsp_count) <= LINES));

  // R10: a purge request starts only from an update that needed one
  a_r10_req_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_req) |-> $past(evict_start));

  // R10: request and victim address hold until acknowledged
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_req && !ev_ack) |=> (ev_req && $stable(ev_region)));

  // R10: the acknowledge ends the request
  a_r10_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_req && ev_ack) |=> !ev_req);

  // R11: nothing is installed while a purge is outstanding
  a_r11_no_install: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_req && !ev_ack) |-> !install_fire);
endmodule

bind region_track_array rta_checker #(
  .LINES(LINES), .CNT_W(CNT_W), .REG_AW(REG_AW)
) u_rta_chk (
  .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_state(rsp_state), .rsp_count(rsp_count), .ev_req(ev_req),
  .ev_ack(ev_ack), .ev_region(ev_region), .install_fire(install_fire),
  .evict_start(evict_start)
);

// File: tb/region_track_array_test.sv
`timescale 1ns/1ps
module region_track_array_test;
  localparam int AW = 24, CW = 4, MW = 6, RW = 21;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          lk_valid = 0, upd_valid = 0, ln_alloc = 0, ln_inval = 0, ev_ack = 0;
  logic [AW-1:0] lk_line = '0, upd_line = '0, ln_alloc_line = '0, ln_inval_line = '0;
  logic [2:0]    upd_state = '0;
  logic [MW-1:0] upd_mcid = '0;
  logic          rsp_valid, rsp_hit, ev_req;
  logic [2:0]    rsp_state;
  logic [CW-1:0] rsp_count;
  logic [MW-1:0] rsp_mcid;
  logic [RW-1:0] ev_region;

  int checks = 0, fails = 0;

  region_track_array uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_line(lk_line),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_state(rsp_state),
    .rsp_count(rsp_count), .rsp_mcid(rsp_mcid), .upd_valid(upd_valid),
    .upd_line(upd_line), .upd_state(upd_state), .upd_mcid(upd_mcid),
    .ln_alloc(ln_alloc), .ln_alloc_line(ln_alloc_line), .ln_inval(ln_inval),
    .ln_inval_line(ln_inval_line), .ev_req(ev_req), .ev_region(ev_region),
    .ev_ack(ev_ack)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic          hit;
    logic [2:0]    st;
    logic [CW-1:0] cnt;
    logic [MW-1:0] mc;
    string         req;
  } exp_t;
  exp_t sb[$];

  // bench's own address composition: {tag, set, line-in-region}
  function automatic logic [AW-1:0] la(input int tag, input int set, input int off);
    return {tag[14:0], set[5:0], off[2:0]};
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // driver tasks: called at a negedge, return at the next negedge
  task automatic lookup(input logic [AW-1:0] a, input logic h, input int st,
                        input int cnt, input int mc, input string req);
    exp_t e;
    e.hit = h; e.st = 3'(st); e.cnt = CW'(cnt); e.mc = MW'(mc); e.req = req;
    sb.push_back(e);
    lk_valid = 1; lk_line = a;
    @(negedge clk);
    lk_valid = 0;
  endtask

  task automatic update(input logic [AW-1:0] a, input int st, input int mc);
    upd_valid = 1; upd_line = a; upd_state = 3'(st); upd_mcid = MW'(mc);
    @(negedge clk);
    upd_valid = 0;
  endtask

  task automatic notify(input logic al, input logic [AW-1:0] aa,
                        input logic iv, input logic [AW-1:0] ia);
    ln_alloc = al; ln_alloc_line = aa; ln_inval = iv; ln_inval_line = ia;
    @(negedge clk);
    ln_alloc = 0; ln_inval = 0;
  endtask

  // monitor: compare every lookup answer with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        check("R2", "unexpected response", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(e.req, "hit", int'(rsp_hit), int'(e.hit));
        check(e.req, "state", int'(rsp_state), int'(e.st));
        check(e.req, "count", int'(rsp_count), int'(e.cnt));
        check(e.req, "mcid", int'(rsp_mcid), int'(e.mc));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all-requirements actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  localparam int S = 5, T = 9;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 / R2: empty after reset
    check("R1", "ev_req after reset", int'(ev_req), 0);
    lookup(la(1, S, 0), 0, 0, 0, 0, "R1");

    // R3 / R7: install then hit from another offset, not from another set
    update(la(1, S, 0), 3, 7);
    check("R3", "no purge on free way", int'(ev_req), 0);
    lookup(la(1, S, 6), 1, 3, 0, 7, "R7");
    lookup(la(1, S + 1, 0), 0, 0, 0, 0, "R7");

    // R5 / R6: counting
    notify(1, la(1, S, 1), 0, '0);
    notify(1, la(1, S, 2), 0, '0);
    lookup(la(1, S, 0), 1, 3, 2, 7, "R5");
    notify(0, '0, 1, la(1, S, 1));
    lookup(la(1, S, 0), 1, 3, 1, 7, "R6");
    notify(1, la(1, S, 3), 1, la(1, S, 4));
    lookup(la(1, S, 0), 1, 3, 1, 7, "R6");
    notify(1, la(9, S, 0), 1, la(8, S, 0));
    lookup(la(1, S, 0), 1, 3, 1, 7, "R5");
    lookup(la(9, S, 0), 0, 0, 0, 0, "R5");
    for (int i = 0; i < 10; i++) notify(1, la(1, S, i % 8), 0, '0);
    lookup(la(1, S, 0), 1, 3, 8, 7, "R5");
    for (int i = 0; i < 10; i++) notify(0, '0, 1, la(1, S, i % 8));
    lookup(la(1, S, 0), 1, 3, 0, 7, "R6");
    notify(1, la(1, S, 0), 0, '0);
    notify(1, la(1, S, 1), 0, '0);

    // R4: state rewrite keeps count
    update(la(1, S, 5), 5, 2);
    lookup(la(1, S, 0), 1, 5, 2, 2, "R4");

    // R8: invalid way first, then zero-count way even if most recent
    update(la(2, S, 0), 1, 1);
    check("R8", "no purge into invalid way", int'(ev_req), 0);
    lookup(la(1, S, 0), 1, 5, 2, 2, "R8");
    lookup(la(2, S, 0), 1, 1, 0, 1, "R8");
    update(la(3, S, 0), 2, 3);
    check("R8", "zero-count victim silent", int'(ev_req), 0);
    lookup(la(2, S, 0), 0, 0, 0, 0, "R8");
    lookup(la(1, S, 0), 1, 5, 2, 2, "R8");
    lookup(la(3, S, 0), 1, 2, 0, 3, "R8");

    // R9: all ways zero, least recent goes
    update(la(1, T, 0), 1, 10);
    update(la(2, T, 0), 1, 11);
    lookup(la(1, T, 0), 1, 1, 0, 10, "R9");
    update(la(3, T, 0), 4, 12);
    check("R9", "no purge all-zero set", int'(ev_req), 0);
    lookup(la(2, T, 0), 0, 0, 0, 0, "R9");
    lookup(la(1, T, 0), 1, 1, 0, 10, "R9");
    lookup(la(3, T, 0), 1, 4, 0, 12, "R9");

    // R10 / R11: both ways hold lines, LRU region is purged
    notify(1, la(3, S, 2), 0, '0);
    lookup(la(3, S, 0), 1, 2, 1, 3, "R10");
    lookup(la(1, S, 0), 1, 5, 2, 2, "R10");
    update(la(4, S, 0), 6, 4);
    check("R10", "ev_req raised", int'(ev_req), 1);
    check("R10", "ev_region", int'(ev_region), int'({15'(3), 6'(S)}));
    update(la(5, S, 0), 7, 9);
    lookup(la(3, S, 0), 1, 2, 1, 3, "R10");
    lookup(la(4, S, 0), 0, 0, 0, 0, "R10");
    notify(0, '0, 1, la(3, S, 2));
    check("R10", "ev_req held", int'(ev_req), 1);
    check("R10", "ev_region held", int'(ev_region), int'({15'(3), 6'(S)}));
    ev_ack = 1;
    @(negedge clk);
    ev_ack = 0;
    check("R10", "ev_req dropped", int'(ev_req), 0);
    lookup(la(4, S, 0), 1, 6, 0, 4, "R10");
    lookup(la(3, S, 0), 0, 0, 0, 0, "R10");
    lookup(la(5, S, 0), 0, 0, 0, 0, "R11");
    lookup(la(1, S, 0), 1, 5, 2, 2, "R10");

    repeat (3) @(negedge clk);
    check("R2", "scoreboard drained", sb.size(), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule